// File: doc/BRIEF.md
# Frequency Synthesizer Control and Lock Sequencer

This block is the digital side of an on-chip frequency synthesizer. It owns a small control register. The register holds a six-bit loop multiplier, a range bit and a post-divide select bit. It also carries a read-only lock flag. The loop multiplier and range bit set the feedback ratio handed to the external oscillator loop, which can reach a factor of 256. The post-divide bit picks whether the delivered system clock is the oscillator clock divided by four or by two. The post-divide stage lies outside the loop, so changing it never disturbs lock.

The block runs on the oscillator clock itself. A one-cycle `ref_tick` strobe marks each reference period. An asynchronous `lock_det` input reports lock from the analog loop detector. A write that alters the in-loop fields starts a relock interval. During that interval the lock flag reads zero for a fixed number of reference periods, and then it follows the synchronized detector. After power-on, the chip reset output stays asserted until the first time the lock flag is set.

Top module: `csynth_ctrl`

## Requirements
- R1: The write word is laid out as bit 7 = W (range), bit 6 = X (post-divide select), bits 5:0 = Y (multiplier). The read word uses the same bits, with bit 8 = lock flag. After power-on, W=0, X=0 and Y=63, so `rd_data` reads 9'h03F.
- R2: `loop_ratio` equals (Y+1) when W=0 and 4*(Y+1) when W=1. The range is 1 to 256.
- R3: With X=0, `sys_clk_o` has a period of four `clk` cycles, with a high half and a low half of two cycles each. With X=1, the period is two cycles, with one cycle high and one cycle low.
- R4: A change of X takes effect only at the end of a full output period. The last period at the old rate completes with its full high and low halves, and the first period at the new rate starts with its low half.
- R5: A write whose W or Y differs from the held value makes the lock flag read 0 from the next cycle on. The flag stays 0 for at least 16 `ref_tick` pulses. After that, it reads 1 only while the synchronized detector reports lock.
- R6: A write that leaves W and Y unchanged, such as a change of X only, does not clear the lock flag and starts no relock interval.
- R7: `lock_det` passes through a two-flop synchronizer. A change at its input reaches the lock flag after the second rising `clk` edge, and not before.
- R8: `rst_out_n` is low from power-on until the first cycle in which the lock flag is 1. After that it stays high regardless of later loss of lock.
- R9: Writes accepted while `rst_out_n` is low update the register fields. They do not themselves release `rst_out_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all logic runs on it |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| lock_det | input | 1 | Asynchronous lock indication from the loop detector |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write word {W, X, Y[5:0]} |
| rd_data | output | 9 | Read word {lock, W, X, Y[5:0]} |
| loop_ratio | output | 9 | Feedback multiplication ratio for the loop |
| sys_clk_o | output | 1 | Post-divided system clock |
| rst_out_n | output | 1 | Chip reset output, active low |

## Verification
The assertions assume that `ref_tick` is a single-cycle pulse and that `wr_en` lasts exactly one cycle per write. They also assume that `lock_det` may change at any time, because the synchronizer absorbs its timing. The stimulus keeps to these assumptions in three ways. It generates `ref_tick` every eight cycles from its own free-running process. It issues every write as a one-cycle strobe placed on a falling edge. It drives `lock_det` only on falling edges, so the two-cycle synchronizer delay is counted from a known edge.

// File: rtl/csynth_pkg.sv
package csynth_pkg;

  typedef struct packed {
    logic       w;
    logic       x;
    logic [5:0] y;
  } synctl_t;

  localparam int unsigned WR_W    = 8;
  localparam int unsigned RD_W    = 9;
  localparam int unsigned RATIO_W = 9;

  // Feedback ratio from the in-loop fields: (Y+1) scaled by 4 when W is set.
  function automatic logic [RATIO_W-1:0] loop_ratio_f(input logic w, input logic [5:0] y);
    logic [RATIO_W-1:0] base;
    base = {3'b000, y} + 9'd1;
    return w ? (base << 2) : base;
  endfunction

  function automatic logic [RD_W-1:0] pack_rd_f(input synctl_t c, input logic lk);
    return {lk, c.w, c.x, c.y};
  endfunction

  // True when a write word alters a field that sits inside the loop.
  function automatic logic in_loop_change_f(input synctl_t cur, input synctl_t nxt);
    return (cur.w != nxt.w) || (cur.y != nxt.y);
  endfunction

endpackage

// File: rtl/csynth_sync2.sv
module csynth_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/csynth_postdiv.sv
module csynth_postdiv (
  input  logic clk,
  input  logic por_n,
  input  logic x_sel,
  output logic sys_clk,
  output logic period_end
);
  logic [1:0] phase;
  logic       act_x;

  // Last count of the current period: 1 when halving, 3 when quartering.
  assign period_end = act_x ? (phase == 2'd1) : (phase == 2'd3);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase <= 2'd0;
      act_x <= 1'b0;
    end else if (period_end) begin
      phase <= 2'd0;
      act_x <= x_sel;
    end else begin
      phase <= phase + 2'd1;
    end
  end

  assign sys_clk = act_x ? phase[0] : phase[1];

  // R4: the divide selection only moves on the edge that closes a period
  a_r4_switch_on_period_end: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(act_x) |-> $past(period_end));

  // R4: every period begins low
  a_r4_period_starts_low: assert property (@(posedge clk) disable iff (!por_n)
    $past(period_end) |-> !sys_clk);
endmodule

// File: rtl/csynth_lock_seq.sv
module csynth_lock_seq #(
  parameter int unsigned MASK_REFS = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic ref_tick,
  input  logic lock_s,
  input  logic relock_req,
  output logic slock,
  output logic rst_out_n
);
  localparam int unsigned CW = $clog2(MASK_REFS + 1);

  logic [CW-1:0] mask_cnt;
  logic          mask_done;

  assign mask_done = (mask_cnt == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     mask_cnt <= CW'(MASK_REFS);
    else if (relock_req)            mask_cnt <= CW'(MASK_REFS);
    else if (ref_tick && !mask_done) mask_cnt <= mask_cnt - 1'b1;
  end

  assign slock = lock_s && mask_done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     rst_out_n <= 1'b0;
    else if (slock) rst_out_n <= 1'b1;
  end

  // R5: a loop-field change hides lock on the following cycle
  a_r5_relock_masks: assert property (@(posedge clk) disable iff (!por_n)
    relock_req |=> !slock);

  // R5: the flag never claims lock the synchronizer does not report
  a_r5_flag_needs_lock: assert property (@(posedge clk) disable iff (!por_n)
    slock |-> lock_s);

  // R8: reset release is caused by a lock indication
  a_r8_release_on_lock: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> $past(slock));

  // R8: once released, reset stays released
  a_r8_release_sticky: assert property (@(posedge clk) disable iff (!por_n)
    rst_out_n |=> rst_out_n);
endmodule

// File: rtl/csynth_ctrl.sv
module csynth_ctrl
  import csynth_pkg::*;
#(
  parameter int unsigned MASK_REFS = 16,
  parameter logic [5:0]  RST_Y     = 6'd63
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               ref_tick,
  input  logic               lock_det,
  input  logic               wr_en,
  input  logic [WR_W-1:0]    wr_data,
  output logic [RD_W-1:0]    rd_data,
  output logic [RATIO_W-1:0] loop_ratio,
  output logic               sys_clk_o,
  output logic               rst_out_n
);
  synctl_t ctl_q;
  synctl_t wr_word;
  logic    relock_req;
  logic    lock_s;
  logic    slock;
  logic    period_end;

  assign wr_word    = synctl_t'(wr_data);
  assign relock_req = wr_en && in_loop_change_f(ctl_q, wr_word);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     ctl_q <= '{w: 1'b0, x: 1'b0, y: RST_Y};
    else if (wr_en) ctl_q <= wr_word;
  end

  csynth_sync2 #(.STAGES(2)) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .d_async(lock_det),
    .q_sync (lock_s)
  );

  csynth_lock_seq #(.MASK_REFS(MASK_REFS)) u_lock (
    .clk       (clk),
    .por_n     (por_n),
    .ref_tick  (ref_tick),
    .lock_s    (lock_s),
    .relock_req(relock_req),
    .slock     (slock),
    .rst_out_n (rst_out_n)
  );

  csynth_postdiv u_div (
    .clk       (clk),
    .por_n     (por_n),
    .x_sel     (ctl_q.x),
    .sys_clk   (sys_clk_o),
    .period_end(period_end)
  );

  assign rd_data    = pack_rd_f(ctl_q, slock);
  assign loop_ratio = loop_ratio_f(ctl_q.w, ctl_q.y);

  // R6: an out-of-loop write leaves lock alone unless the detector drops
  a_r6_x_write_keeps_lock: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !relock_req && slock) |=> (slock || !lock_s));

  // R9: a write during reset hold does not open reset by itself
  a_r9_write_no_release: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !rst_out_n && !slock) |=> !rst_out_n);

  // R2: ratio stays inside the reachable range
  always_comb begin
    if (por_n) begin
      a_r2_ratio_range: assert (loop_ratio >= 9'd1 && loop_ratio <= 9'd256);
    end
  end
endmodule

// File: tb/csynth_ctrl_tb_top.sv
module csynth_ctrl_tb_top;
  localparam int REF_DIV = 8;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       lock_det = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [8:0] rd_data;
  logic [8:0] loop_ratio;
  logic       sys_clk_o;
  logic       rst_out_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csynth_ctrl dut_i (
    .clk(clk), .por_n(por_n), .ref_tick(ref_tick), .lock_det(lock_det),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .loop_ratio(loop_ratio), .sys_clk_o(sys_clk_o), .rst_out_n(rst_out_n)
  );

  initial begin
    forever begin
      repeat (REF_DIV - 1) @(negedge clk);
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
    end
  end

  // {w, x, y[5:0], ratio[8:0], half_len[1:0]}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd0,  9'd1,   2'd2},
    {1'b0, 1'b0, 6'd63, 9'd64,  2'd2},
    {1'b1, 1'b1, 6'd63, 9'd256, 2'd1},
    {1'b1, 1'b1, 6'd0,  9'd4,   2'd1},
    {1'b1, 1'b0, 6'd0,  9'd4,   2'd2},
    {1'b0, 1'b1, 6'd10, 9'd11,  2'd1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Checks that all complete high/low runs of sys_clk_o have length len.
  task automatic run_len(input string req, input int len);
    logic prev;
    int run, bad;
    bad = 0; run = 0;
    @(negedge clk);
    prev = sys_clk_o;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (sys_clk_o != prev) break; end
    prev = sys_clk_o; run = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (sys_clk_o == prev) run++;
      else begin
        if (run != len) bad++;
        prev = sys_clk_o; run = 1;
      end
    end
    chk(req, "half-period length mismatches", bad, 0);
  endtask

  // Writes a new X mid-stream and checks the run sequence across the switch.
  task automatic switch_chk(input string req, input logic [7:0] d, input int from_len, input int to_len);
    logic smp [0:39];
    int rl [0:39];
    logic lv [0:39];
    int n, bad, first_new;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wr_en = (i == 10);
      if (i == 10) wr_data = d;
      smp[i] = sys_clk_o;
    end
    wr_en = 1'b0;
    n = 0; rl[0] = 1; lv[0] = smp[0];
    for (int i = 1; i < 40; i++) begin
      if (smp[i] == smp[i-1]) rl[n]++;
      else begin n++; rl[n] = 1; lv[n] = smp[i]; end
    end
    bad = 0; first_new = -1;
    for (int k = 1; k < n; k++) begin
      if (rl[k] == to_len && first_new < 0) first_new = k;
      else if (rl[k] != to_len && rl[k] != from_len) bad++;
      else if (first_new >= 0 && rl[k] != to_len) bad++;
    end
    chk(req, "runs not old-then-new", bad, 0);
    chk(req, "switch found", (first_new > 0), 1);
    if (first_new > 0) chk(req, "first new-rate run level", lv[first_new], 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic pw;
    logic [5:0] py;
    repeat (5) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset rd_data", rd_data, 9'h03F);
    chk("R2", "reset ratio", loop_ratio, 9'd64);
    chk("R8", "reset held at power-on", rst_out_n, 1'b0);
    run_len("R3", 2);
    // R9 write during hold
    wr(8'h85);
    chk("R9", "field update during hold", rd_data, 9'h085);
    chk("R2", "ratio after hold write", loop_ratio, 9'd24);
    repeat (30 * REF_DIV) @(negedge clk);
    chk("R9", "still held without lock", rst_out_n, 1'b0);
    lock_det = 1'b1;
    repeat (20 * REF_DIV) @(negedge clk);
    chk("R8", "released after lock", rst_out_n, 1'b1);
    chk("R5", "lock flag set", rd_data[8], 1'b1);

    pw = 1'b1; py = 6'd5;
    for (int v = 0; v < 6; v++) begin
      logic w, x; logic [5:0] y; logic [8:0] r; int hl;
      {w, x, y, r, hl} = {VEC[v][18], VEC[v][17], VEC[v][16:11], VEC[v][10:2], 32'(VEC[v][1:0])};
      wr({w, x, y});
      if (w != pw || y != py) chk("R5", "flag cleared by loop write", rd_data[8], 1'b0);
      else                    chk("R6", "flag kept by X-only write", rd_data[8], 1'b1);
      chk("R1", "readback fields", rd_data[7:0], {w, x, y});
      chk("R2", "ratio", loop_ratio, r);
      repeat (20 * REF_DIV) @(negedge clk);
      chk("R5", "relocked", rd_data[8], 1'b1);
      run_len("R3", hl);
      pw = w; py = y;
    end

    // R5 minimum mask window
    wr(8'h01);
    repeat (14 * REF_DIV) @(negedge clk);
    chk("R5", "still masked within window", rd_data[8], 1'b0);
    repeat (4 * REF_DIV) @(negedge clk);
    chk("R5", "lock after window", rd_data[8], 1'b1);
    // R5 mask expires but detector low
    lock_det = 1'b0;
    wr(8'h02);
    repeat (20 * REF_DIV) @(negedge clk);
    chk("R5", "no lock while detector low", rd_data[8], 1'b0);
    lock_det = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5", "lock follows detector", rd_data[8], 1'b1);

    // R7 synchronizer latency
    lock_det = 1'b0;
    @(negedge clk);
    chk("R7", "one edge after drop", rd_data[8], 1'b1);
    @(negedge clk);
    chk("R7", "two edges after drop", rd_data[8], 1'b0);
    chk("R8", "reset stays released", rst_out_n, 1'b1);
    lock_det = 1'b1;
    @(negedge clk);
    chk("R7", "one edge after rise", rd_data[8], 1'b0);
    @(negedge clk);
    chk("R7", "two edges after rise", rd_data[8], 1'b1);

    // R4 glitch-free switching at several phases; R6 lock kept
    for (int off = 0; off < 4; off++) begin
      wr(8'h02);
      repeat (8 + off) @(negedge clk);
      switch_chk("R4", 8'h42, 2, 1);
      chk("R6", "lock after X to 1", rd_data[8], 1'b1);
      repeat (off) @(negedge clk);
      switch_chk("R4", 8'h02, 1, 2);
      chk("R6", "lock after X to 0", rd_data[8], 1'b1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule